// File: doc/BRIEF.md
# Path Overhead Parity Generator and Inserter

This block sits on the transmit side of a concatenated three-channel synchronous payload envelope. A byte-wide stream enters with three qualifiers. One marks bytes that belong to the envelope. One marks the first envelope byte, which is the trace position that opens the path-overhead column. One marks each path-overhead column position, one per row. The block fills every path-overhead slot from configuration inputs and leaves payload bytes and non-envelope bytes as they are. Each byte comes out one clock later.

The parity slot (second row) carries an even-parity bit-interleaved byte. It is computed over every transmitted byte of the previous envelope, not the current one. A test mask is XOR-ed into that byte so that chosen parity bits can be corrupted on purpose. The status byte (fourth row) carries the remote error count and the remote defect flag. Each can come from a live input or from a force control. A further control replaces the whole envelope with all-ones to signal a path alarm.

Top module: `path_parity_inserter`

## Requirements
- R1: While reset is low, and on the first output cycle after it, `out_byte` is 0x00 and `out_spe` is low. The first parity slot after reset carries 0x00 XOR `cfg_b3_mask`.
- R2: Every byte leaves exactly one clock after it enters. `out_spe` repeats `in_spe`. Bytes with `in_spe` low pass unchanged.
- R3: Envelope bytes that are not path-overhead positions pass unchanged while `ais_force` is low.
- R4: Path-overhead rows are counted from the byte with `in_first` high, in the order 0 trace, 1 parity, 2 signal label, 3 status, 4 user channel, 5 multiframe, 6 to 8 growth. Rows 0, 2, 4, 5, 6, 7 and 8 carry `cfg_j1`, `cfg_c2`, `cfg_f2`, `cfg_h4`, `cfg_z3`, `cfg_z4` and `cfg_z5` respectively.
- R5: The parity slot carries the XOR of every transmitted byte of the previous envelope, from its first byte up to the byte before the next `in_first`. This includes the transmitted parity byte of that envelope.
- R6: The transmitted parity byte equals the computed parity XOR `cfg_b3_mask`. A zero mask leaves the parity clean, and a non-zero mask inverts exactly its set bits.
- R7: The status byte is {err[3:0], defect, 3'b000}. err is 8 when `rei_force` is high. Otherwise err is `rei_count`, saturated at 8.
- R8: The defect bit of the status byte is `rdi_defect` OR `rdi_force`.
- R9: While `ais_force` is high, every envelope byte, path overhead included, is sent as 0xFF. Those bytes enter the parity like any other transmitted byte.
- R10: Envelope bytes before the first `in_first` after reset pass unchanged, even when marked as path overhead. They do not enter any parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Incoming stream byte |
| in_spe | input | 1 | Byte belongs to the envelope |
| in_first | input | 1 | First envelope byte (row 0 of the overhead column) |
| in_poh | input | 1 | Byte is a path-overhead column position |
| cfg_j1 | input | 8 | Trace byte, row 0 |
| cfg_c2 | input | 8 | Signal label, row 2 |
| cfg_f2 | input | 8 | User channel, row 4 |
| cfg_h4 | input | 8 | Multiframe byte, row 5 |
| cfg_z3 | input | 8 | Growth byte, row 6 |
| cfg_z4 | input | 8 | Growth byte, row 7 |
| cfg_z5 | input | 8 | Growth byte, row 8 |
| cfg_b3_mask | input | 8 | Parity corruption mask |
| rdi_defect | input | 1 | Live remote defect condition |
| rdi_force | input | 1 | Force remote defect flag |
| rei_count | input | 4 | Live received error count |
| rei_force | input | 1 | Force maximum remote error count |
| ais_force | input | 1 | Replace envelope with all-ones |
| out_byte | output | 8 | Outgoing stream byte |
| out_spe | output | 1 | Outgoing envelope qualifier |

## Verification
The assertions check, on every cycle, the behaviours that depend only on the last cycle:
- pass-through of non-envelope and payload bytes;
- the all-ones override;
- the parity slot matching the held previous parity XOR the mask;
- the row counter restarting at the trace position;
- the zero parity held until the first envelope opens.

Only the bench's scenarios can show the rest. These are the parity value itself, which spans a whole envelope of bytes, saturation of the error count, and the effect of alarm envelopes on the parity that follows. The same holds for partial envelopes before the first trace byte and the return to zero parity after a reset in mid-stream.

// File: rtl/poh_pkg.sv
// Package: shared path-overhead row encoding.
// Assumes nine overhead rows with the parity slot in row 1 and status in row 3.
package poh_pkg;
    localparam int POH_ROWS = 9;

    typedef enum logic [3:0] {
        ROW_J1   = 4'd0,
        ROW_B3   = 4'd1,
        ROW_C2   = 4'd2,
        ROW_G1   = 4'd3,
        ROW_F2   = 4'd4,
        ROW_H4   = 4'd5,
        ROW_Z3   = 4'd6,
        ROW_Z4   = 4'd7,
        ROW_Z5   = 4'd8,
        ROW_PAST = 4'd9
    } poh_row_e;
endpackage

// File: rtl/poh_row_tracker.sv
// Module: poh_row_tracker
// Tracks which overhead row the current byte occupies. The row restarts at the
// trace position (in_first) and advances on every overhead byte.
// Assumes in_first coincides with an overhead byte. Before the first trace byte
// after reset, and after row 8, the row reads ROW_PAST.
module poh_row_tracker
    import poh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_spe,
    input  logic     in_first,
    input  logic     in_poh,
    output poh_row_e cur_row
);
    poh_row_e cnt_q;

    // Row of the byte now at the input.
    always_comb begin
        cur_row = in_first ? ROW_J1 : cnt_q;
    end

    // Advance the row after each overhead byte, stopping at ROW_PAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ROW_PAST;
        end else if (in_spe && in_poh && cur_row != ROW_PAST) begin
            cnt_q <= poh_row_e'(4'(cur_row) + 4'd1);
        end
    end

    // A trace byte always moves the next overhead byte to the parity row.
    assert_row_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_spe && in_first && in_poh) |=> (cnt_q == ROW_B3));

    // The counter never leaves the legal range.
    assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (4'(cnt_q) <= 4'(POH_ROWS)));
endmodule

// File: rtl/bip8_accum.sv
// Module: bip8_accum
// Even-parity bit-interleaved accumulator over transmitted envelope bytes.
// At each envelope start it hands the finished parity to prev_parity and
// restarts with the start byte. Nothing accumulates before the first start.
module bip8_accum #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic              tx_start,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] prev_parity
);
    logic              started_q;
    logic [BYTE_W-1:0] acc_q;
    logic [BYTE_W-1:0] prev_q;

    // Fold transmitted bytes into the running parity; roll over at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            acc_q     <= '0;
            prev_q    <= '0;
        end else if (tx_valid && tx_start) begin
            prev_q    <= started_q ? acc_q : '0;
            acc_q     <= tx_byte;
            started_q <= 1'b1;
        end else if (tx_valid && started_q) begin
            acc_q <= acc_q ^ tx_byte;
        end
    end

    assign prev_parity = prev_q;

    // The parity used before any envelope has completed is zero.
    assert_first_parity_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!started_q) |-> (prev_q == '0 && acc_q == '0));

    // The handed-over parity changes only on an envelope start.
    assert_parity_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_valid && tx_start)) |-> $stable(prev_q));
endmodule

// File: rtl/g1_builder.sv
// Module: g1_builder
// Builds the status byte from the remote error count and the defect flag.
// Assumes an 8-bit byte: count in bits 7:4, flag in bit 3, zeros below.
module g1_builder #(
    parameter int REI_W   = 4,
    parameter int REI_MAX = 8
) (
    input  logic [REI_W-1:0] rei_count,
    input  logic             rei_force,
    input  logic             rdi_defect,
    input  logic             rdi_force,
    output logic [7:0]       g1_byte
);
    localparam logic [REI_W-1:0] REI_CAP = REI_W'(REI_MAX);

    logic [REI_W-1:0] rei_val;

    // Pick the forced, saturated or live error count.
    always_comb begin
        if (rei_force) begin
            rei_val = REI_CAP;
        end else if (rei_count > REI_CAP) begin
            rei_val = REI_CAP;
        end else begin
            rei_val = rei_count;
        end
    end

    // Pack the count and the defect flag.
    always_comb begin
        g1_byte = {rei_val[3:0], rdi_defect | rdi_force, 3'b000};
    end
endmodule

// File: rtl/path_parity_inserter.sv
// Module: path_parity_inserter
// Fills path-overhead slots of a transmit envelope from configuration. The
// parity slot gets the previous envelope's parity XOR a test mask, and all
// envelope bytes can be forced to all-ones. Output is registered, one cycle.
// Assumes in_first and in_poh are only meaningful with in_spe high.
module path_parity_inserter
    import poh_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int REI_W   = 4,
    parameter int REI_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_spe,
    input  logic              in_first,
    input  logic              in_poh,
    input  logic [BYTE_W-1:0] cfg_j1,
    input  logic [BYTE_W-1:0] cfg_c2,
    input  logic [BYTE_W-1:0] cfg_f2,
    input  logic [BYTE_W-1:0] cfg_h4,
    input  logic [BYTE_W-1:0] cfg_z3,
    input  logic [BYTE_W-1:0] cfg_z4,
    input  logic [BYTE_W-1:0] cfg_z5,
    input  logic [BYTE_W-1:0] cfg_b3_mask,
    input  logic              rdi_defect,
    input  logic              rdi_force,
    input  logic [REI_W-1:0]  rei_count,
    input  logic              rei_force,
    input  logic              ais_force,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_spe
);
    localparam logic [BYTE_W-1:0] ALL_ONES = '1;

    poh_row_e          cur_row;
    logic [BYTE_W-1:0] prev_parity;
    logic [7:0]        g1_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] out_byte_q;
    logic              out_spe_q;

    poh_row_tracker u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_spe   (in_spe),
        .in_first (in_first),
        .in_poh   (in_poh),
        .cur_row  (cur_row)
    );

    bip8_accum #(.BYTE_W(BYTE_W)) u_parity (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_valid    (in_spe),
        .tx_start    (in_first),
        .tx_byte     (tx_byte),
        .prev_parity (prev_parity)
    );

    g1_builder #(.REI_W(REI_W), .REI_MAX(REI_MAX)) u_g1 (
        .rei_count  (rei_count),
        .rei_force  (rei_force),
        .rdi_defect (rdi_defect),
        .rdi_force  (rdi_force),
        .g1_byte    (g1_byte)
    );

    // Select the byte to transmit: pass-through, alarm fill or overhead slot.
    always_comb begin
        tx_byte = in_byte;
        if (in_spe) begin
            if (ais_force) begin
                tx_byte = ALL_ONES;
            end else if (in_poh) begin
                case (cur_row)
                    ROW_J1:  tx_byte = cfg_j1;
                    ROW_B3:  tx_byte = prev_parity ^ cfg_b3_mask;
                    ROW_C2:  tx_byte = cfg_c2;
                    ROW_G1:  tx_byte = BYTE_W'(g1_byte);
                    ROW_F2:  tx_byte = cfg_f2;
                    ROW_H4:  tx_byte = cfg_h4;
                    ROW_Z3:  tx_byte = cfg_z3;
                    ROW_Z4:  tx_byte = cfg_z4;
                    ROW_Z5:  tx_byte = cfg_z5;
                    default: tx_byte = in_byte;
                endcase
            end
        end
    end

    // Register the outgoing byte and its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte_q <= '0;
            out_spe_q  <= 1'b0;
        end else begin
            out_byte_q <= tx_byte;
            out_spe_q  <= in_spe;
        end
    end

    assign out_byte = out_byte_q;
    assign out_spe  = out_spe_q;

    // Non-envelope bytes reappear unchanged one cycle later.
    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!in_spe)) |-> (out_byte == $past(in_byte) && !out_spe));

    // Payload bytes are untouched without the alarm.
    assert_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_spe && !in_poh && !ais_force))
        |-> (out_byte == $past(in_byte) && out_spe));

    // The alarm fills every envelope byte with ones.
    assert_ais_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_spe && ais_force)) |-> (out_byte == ALL_ONES));

    // The parity slot carries the held parity XOR the mask.
    assert_b3_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_spe && in_poh && !ais_force && cur_row == ROW_B3))
        |-> (out_byte == $past(prev_parity ^ cfg_b3_mask)));
endmodule

// File: tb/path_parity_inserter_test.sv
`timescale 1ns/1ps
module path_parity_inserter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_spe = 1'b0, in_first = 1'b0, in_poh = 1'b0;
    logic [7:0] cfg_j1 = 8'h11, cfg_c2 = 8'h13, cfg_f2 = 8'h22, cfg_h4 = 8'h34;
    logic [7:0] cfg_z3 = 8'h45, cfg_z4 = 8'h56, cfg_z5 = 8'h67, cfg_b3_mask = '0;
    logic       rdi_defect = 1'b0, rdi_force = 1'b0, rei_force = 1'b0, ais_force = 1'b0;
    logic [3:0] rei_count = '0;
    logic [7:0] out_byte;
    logic       out_spe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements.
    bit         m_started;
    logic [7:0] m_acc, m_prev;
    int         m_row;

    // Vector fields: [7:0] mask, [11:8] rei_count, [12] rei_force,
    // [13] rdi_defect, [14] rdi_force, [15] ais_force.
    localparam int NVEC = 10;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0000, 16'h0000, 16'h00A5, 16'h0300, 16'h0F00,
        16'h1200, 16'h2000, 16'h4001, 16'h8000, 16'h0000
    };

    path_parity_inserter uut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_spe(in_spe),
        .in_first(in_first), .in_poh(in_poh), .cfg_j1(cfg_j1), .cfg_c2(cfg_c2),
        .cfg_f2(cfg_f2), .cfg_h4(cfg_h4), .cfg_z3(cfg_z3), .cfg_z4(cfg_z4),
        .cfg_z5(cfg_z5), .cfg_b3_mask(cfg_b3_mask), .rdi_defect(rdi_defect),
        .rdi_force(rdi_force), .rei_count(rei_count), .rei_force(rei_force),
        .ais_force(ais_force), .out_byte(out_byte), .out_spe(out_spe)
    );

    always #2 clk = ~clk;

    task automatic check(input logic [8:0] got, input logic [8:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_started = 1'b0;
        m_acc = '0;
        m_prev = '0;
        m_row = 9;
    endtask

    // Drive one byte, predict its output and compare one cycle later.
    task automatic send(input logic [7:0] b, input logic spe, input logic first,
                        input logic poh);
        int r;
        logic [7:0] e;
        logic [3:0] rei;
        string tag;
        r = first ? 0 : m_row;
        rei = rei_force ? 4'd8 : ((rei_count > 4'd8) ? 4'd8 : rei_count);
        e = b;
        tag = "R3 payload";
        if (!spe) begin
            tag = "R2 pass";
        end else if (ais_force) begin
            e = 8'hFF;
            tag = "R9 alarm";
        end else if (poh && r < 9) begin
            tag = "R4 slot";
            case (r)
                0: e = cfg_j1;
                1: begin e = m_prev ^ cfg_b3_mask; tag = "R5 R6 parity"; end
                2: e = cfg_c2;
                3: begin e = {rei, rdi_defect | rdi_force, 3'b000}; tag = "R7 R8 status"; end
                4: e = cfg_f2;
                5: e = cfg_h4;
                6: e = cfg_z3;
                7: e = cfg_z4;
                default: e = cfg_z5;
            endcase
        end else if (poh) begin
            tag = "R10 unframed";
        end
        if (spe && first) begin
            m_prev = m_started ? m_acc : 8'h00;
            m_acc = e;
            m_started = 1'b1;
        end else if (spe && m_started) begin
            m_acc = m_acc ^ e;
        end
        if (spe && poh && r < 9) m_row = r + 1;
        in_byte = b; in_spe = spe; in_first = first; in_poh = poh;
        @(posedge clk);
        #1;
        check({out_spe, out_byte}, {spe, e}, tag);
    endtask

    // One envelope: nine rows of a transport byte, an overhead byte and payload.
    task automatic send_spe(input int seed);
        for (int row = 0; row < 9; row++) begin
            send(8'(seed + row), 1'b0, 1'b0, 1'b0);
            send(8'(8'h5A ^ row), 1'b1, row == 0, 1'b1);
            for (int k = 0; k < 3; k++) send(8'(seed * 7 + row * 3 + k * 11), 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_spe = 1'b0; in_first = 1'b0; in_poh = 1'b0; in_byte = 8'hC3;
        repeat (3) @(posedge clk);
        #1;
        check({out_spe, out_byte}, 9'h000, "R1 reset");
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        model_reset();
        #1;
        do_reset();
        // R1: first output after reset comes from the first byte driven.
        send(8'h3C, 1'b0, 1'b0, 1'b0);
        // R10: overhead-flagged bytes before the first trace byte.
        for (int i = 0; i < 4; i++) send(8'(8'h90 + i), 1'b1, 1'b0, i[0]);
        // R1 R6: first parity after reset is the mask alone.
        cfg_b3_mask = 8'h3C;
        send_spe(3);
        cfg_b3_mask = 8'h00;
        // Table of configurations, one envelope each.
        for (int v = 0; v < NVEC; v++) begin
            cfg_b3_mask = VEC[v][7:0];
            rei_count   = VEC[v][11:8];
            rei_force   = VEC[v][12];
            rdi_defect  = VEC[v][13];
            rdi_force   = VEC[v][14];
            ais_force   = VEC[v][15];
            send_spe(v * 5 + 1);
        end
        // R1: reset in mid-stream restarts with zero parity.
        send(8'h77, 1'b1, 1'b1, 1'b1);
        send(8'h78, 1'b1, 1'b0, 1'b1);
        do_reset();
        send_spe(40);
        send_spe(41);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule